// File: doc/BRIEF.md
# Jitter Attenuator Loop Order Controller

This block is the digital loop filter for one tributary jitter attenuator. On each update tick it reads the fill level of the elastic store and takes its signed distance from mid-range as the phase error. It then produces a frequency-control word for a numerically controlled output clock. In normal operation the loop is second order. A proportional path multiplies the phase error by a programmable scale value. An integral accumulator sums the phase error, and it adds to the output only once its magnitude is above a programmable threshold. Together these two terms set the damping and the natural frequency of the loop.

When a pointer adjustment is signalled, a loadable down-counter takes a programmed duration. While that counter is nonzero the integral path is removed and the accumulator is frozen. This gives a first-order response with no transient peaking. The counter advances once every 16 or 32 clock cycles. When it reaches zero, second-order tracking resumes with the accumulator value that was held. Two complete parameter sets exist, one for E1 and one for DS1 rates, and a per-channel select input chooses between them. Software programs the block through a plain write port.

Top module: `jaloop_ctrl`

## Requirements
- R1: After reset, freq_word equals the nominal word NOM_FCW (default 0x800000), loop_order is 0, and every configuration register is zero.
- R2: The phase error is fill_level minus 2^(FILL_W-1). The proportional term is the phase error times the scale value of the set chosen by mode_ds1 (0 selects E1, 1 selects DS1).
- R3: On each tick in second-order mode, the accumulator adds the phase error and saturates symmetrically at plus or minus (2^GAIN_W - 1). Its value adds to the output only when its magnitude is strictly greater than the gain threshold of the selected set.
- R4: freq_word changes only at a clock edge where tick is high. It becomes NOM_FCW plus the proportional term plus the integral term, clamped to the range 0 to 2^FCW_W - 1.
- R5: A ptr_adj pulse loads the duration register of the selected set into the down-counter. loop_order is 1 exactly while the counter is nonzero.
- R6: Control bit 0 selects the decrement period: 0 gives 16 cycles and 1 gives 32 cycles. The prescaler restarts on every load, so a duration N gives first-order operation for exactly N times the period, counted from the load edge. The counter stops at zero.
- R7: A ptr_adj pulse that arrives while the counter is running reloads the full duration and restarts the prescaler.
- R8: In first-order mode the integral term is excluded from freq_word and the accumulator holds its value. After the return to second order, the held value contributes again.
- R9: Register addresses on cfg_addr: 0 is E1 gain (bits 26:0), 1 is E1 scale (bits 15:0), 2 is E1 duration (bits 20:0), 3 is control (bit 0), 4 is DS1 gain, 5 is DS1 scale, 6 is DS1 duration.
- R10: A ptr_adj pulse while the selected duration is zero leaves loop_order at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Loop update strobe |
| fill_level | input | FILL_W | Elastic-store fill level |
| ptr_adj | input | 1 | Pointer-adjustment pulse |
| mode_ds1 | input | 1 | Parameter set select: 0 selects E1, 1 selects DS1 |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | CFG_DW | Register write data |
| freq_word | output | FCW_W | Frequency-control word |
| loop_order | output | 1 | 0 means second order, 1 means first order |

## Verification
The bench aims at the exact length of the first-order window for both prescaler periods and for both parameter sets. A counter off by one period, or a prescaler that is not restarted on load, would move the falling edge of loop_order. A second pulse partway through the window must stretch it by a full duration; a design that ignored the pulse would end the window early. The threshold test sits on the equal-magnitude case, where a greater-or-equal compare would add the accumulator one tick too soon. The freeze test checks that first-order ticks neither feed nor lose the accumulator. The output clamp is driven into both the low end and the high end.

// File: rtl/jaloop_pkg.sv
package jaloop_pkg;
  localparam int FILL_W_DEF  = 8;
  localparam int GAIN_W_DEF  = 27;
  localparam int SCALE_W_DEF = 16;
  localparam int DUR_W_DEF   = 21;
  localparam int FCW_W_DEF   = 24;

  // register field within a parameter set (address bits 1:0)
  typedef enum logic [1:0] {
    FLD_GAIN  = 2'd0,
    FLD_SCALE = 2'd1,
    FLD_DUR   = 2'd2,
    FLD_CTRL  = 2'd3
  } cfg_field_e;

  typedef enum logic {
    ORDER_SECOND = 1'b0,
    ORDER_FIRST  = 1'b1
  } loop_order_e;
endpackage

// File: rtl/jaloop_regs.sv
module jaloop_regs
  import jaloop_pkg::*;
#(
  parameter int GAIN_W  = GAIN_W_DEF,
  parameter int SCALE_W = SCALE_W_DEF,
  parameter int DUR_W   = DUR_W_DEF,
  parameter int CFG_DW  = GAIN_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  input  logic               mode_ds1,
  output logic [GAIN_W-1:0]  gain_o,
  output logic [SCALE_W-1:0] scale_o,
  output logic [DUR_W-1:0]   dur_o,
  output logic               div32_o
);
  logic [GAIN_W-1:0]  gain_a  [2];
  logic [SCALE_W-1:0] scale_a [2];
  logic [DUR_W-1:0]   dur_a   [2];
  logic               div32_q;

  // address bit 2 picks the set (0 = E1, 1 = DS1), bits 1:0 the field
  for (genvar s = 0; s < 2; s++) begin : g_set
    logic               hit;
    logic [GAIN_W-1:0]  gain_r;
    logic [SCALE_W-1:0] scale_r;
    logic [DUR_W-1:0]   dur_r;

    assign hit = cfg_we && (cfg_addr[2] == 1'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gain_r  <= '0;
        scale_r <= '0;
        dur_r   <= '0;
      end else if (hit) begin
        if (cfg_addr[1:0] == FLD_GAIN)  gain_r  <= cfg_wdata[GAIN_W-1:0];
        if (cfg_addr[1:0] == FLD_SCALE) scale_r <= cfg_wdata[SCALE_W-1:0];
        if (cfg_addr[1:0] == FLD_DUR)   dur_r   <= cfg_wdata[DUR_W-1:0];
      end
    end

    assign gain_a[s]  = gain_r;
    assign scale_a[s] = scale_r;
    assign dur_a[s]   = dur_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      div32_q <= 1'b0;
    else if (cfg_we && cfg_addr == {1'b0, FLD_CTRL})
      div32_q <= cfg_wdata[0];
  end

  assign gain_o  = gain_a[mode_ds1];
  assign scale_o = scale_a[mode_ds1];
  assign dur_o   = dur_a[mode_ds1];
  assign div32_o = div32_q;

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (dur_a[0] == '0 && dur_a[1] == '0 && !div32_q));
endmodule

// File: rtl/jaloop_hold.sv
module jaloop_hold #(
  parameter int DUR_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             div32_i,
  output logic             first_o
);
  localparam int PRE_W = 5;

  logic [PRE_W-1:0] presc_q;
  logic [DUR_W-1:0] cnt_q;
  logic             pre_wrap;
  logic             dec_evt;

  assign pre_wrap = div32_i ? (presc_q == '1) : (presc_q[PRE_W-2:0] == '1);
  assign dec_evt  = !load_i && pre_wrap && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      presc_q <= '0;
      cnt_q   <= dur_i;
    end else begin
      presc_q <= presc_q + PRE_W'(1);
      if (dec_evt) cnt_q <= cnt_q - DUR_W'(1);
    end
  end

  assign first_o = (cnt_q != '0);

  assert_load_takes_duration_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(dur_i));
  assert_count_steps_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - DUR_W'(1)));
  assert_stops_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);
  assert_zero_duration_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && dur_i == '0) |=> !first_o);
endmodule

// File: rtl/jaloop_filter.sv
module jaloop_filter #(
  parameter int FILL_W  = 8,
  parameter int GAIN_W  = 27,
  parameter int SCALE_W = 16,
  parameter int FCW_W   = 24,
  parameter logic [FCW_W-1:0] NOM_FCW = 24'h800000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [FILL_W-1:0]  fill_i,
  input  logic               first_i,
  input  logic [GAIN_W-1:0]  gain_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [FCW_W-1:0]   fcw_o
);
  localparam int ERR_W  = FILL_W + 1;
  localparam int ACC_W  = GAIN_W + 1;
  localparam int PROD_W = ERR_W + SCALE_W + 1;
  localparam int BIG1   = (ACC_W > PROD_W) ? ACC_W : PROD_W;
  localparam int BIG2   = (BIG1 > FCW_W + 1) ? BIG1 : FCW_W + 1;
  localparam int SUM_W  = BIG2 + 2;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W:0]   S_MAX   = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W:0]   S_MIN   = -S_MAX;
  localparam logic signed [SUM_W-1:0] FCW_TOP = {{(SUM_W-FCW_W){1'b0}}, {FCW_W{1'b1}}};

  function automatic logic signed [ERR_W-1:0] f_err(input logic [FILL_W-1:0] f);
    return $signed({1'b0, f}) - $signed({2'b01, {(FILL_W-1){1'b0}}});
  endfunction

  function automatic logic signed [ACC_W-1:0] f_acc_step(
      input logic signed [ACC_W-1:0] a, input logic signed [ERR_W-1:0] e);
    logic signed [ACC_W:0] s;
    s = $signed({a[ACC_W-1], a}) + $signed({{(ACC_W+1-ERR_W){e[ERR_W-1]}}, e});
    if (s > S_MAX)      return ACC_MAX;
    else if (s < S_MIN) return -ACC_MAX;
    else                return s[ACC_W-1:0];
  endfunction

  function automatic logic signed [ACC_W-1:0] f_integ(
      input logic signed [ACC_W-1:0] a, input logic [GAIN_W-1:0] g);
    logic [ACC_W-1:0] mag;
    mag = a[ACC_W-1] ? ACC_W'(-a) : a;
    return (mag > {1'b0, g}) ? a : '0;
  endfunction

  function automatic logic [FCW_W-1:0] f_fcw(
      input logic signed [ERR_W-1:0] e, input logic [SCALE_W-1:0] sc,
      input logic signed [ACC_W-1:0] integ);
    logic signed [SUM_W-1:0] prod, tot;
    prod = $signed({{(SUM_W-ERR_W){e[ERR_W-1]}}, e})
         * $signed({{(SUM_W-SCALE_W){1'b0}}, sc});
    tot  = prod + $signed({{(SUM_W-ACC_W){integ[ACC_W-1]}}, integ})
         + $signed({{(SUM_W-FCW_W){1'b0}}, NOM_FCW});
    if (tot < 0)            return '0;
    else if (tot > FCW_TOP) return '1;
    else                    return tot[FCW_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_nx;
  logic signed [ACC_W-1:0] integ_w;
  logic signed [ERR_W-1:0] err_w;
  logic [FCW_W-1:0]        fcw_q;
  logic                    acc_upd;

  assign err_w   = f_err(fill_i);
  assign acc_nx  = f_acc_step(acc_q, err_w);
  assign acc_upd = tick_i && !first_i;
  assign integ_w = first_i ? '0 : f_integ(acc_nx, gain_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      fcw_q <= NOM_FCW;
    end else begin
      if (acc_upd) acc_q <= acc_nx;
      if (tick_i)  fcw_q <= f_fcw(err_w, scale_i, integ_w);
    end
  end

  assign fcw_o = fcw_q;

  assert_acc_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    first_i |=> $stable(acc_q));
  assert_fcw_only_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(fcw_o));
  assert_acc_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q != {1'b1, {(ACC_W-1){1'b0}}});
  assert_reset_nominal_R1: assert property (@(posedge clk)
    !rst_n |=> fcw_o == NOM_FCW);
endmodule

// File: rtl/jaloop_ctrl.sv
module jaloop_ctrl
  import jaloop_pkg::*;
#(
  parameter int FILL_W  = FILL_W_DEF,
  parameter int GAIN_W  = GAIN_W_DEF,
  parameter int SCALE_W = SCALE_W_DEF,
  parameter int DUR_W   = DUR_W_DEF,
  parameter int FCW_W   = FCW_W_DEF,
  parameter logic [FCW_W-1:0] NOM_FCW = 24'h800000,
  localparam int CFG_DW = (GAIN_W > SCALE_W)
                          ? ((GAIN_W > DUR_W) ? GAIN_W : DUR_W)
                          : ((SCALE_W > DUR_W) ? SCALE_W : DUR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [FILL_W-1:0] fill_level,
  input  logic              ptr_adj,
  input  logic              mode_ds1,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [FCW_W-1:0]  freq_word,
  output logic              loop_order
);
  logic [GAIN_W-1:0]  sel_gain;
  logic [SCALE_W-1:0] sel_scale;
  logic [DUR_W-1:0]   sel_dur;
  logic               div32;
  logic               first_order;

  jaloop_regs #(
    .GAIN_W(GAIN_W), .SCALE_W(SCALE_W), .DUR_W(DUR_W), .CFG_DW(CFG_DW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mode_ds1(mode_ds1), .gain_o(sel_gain),
    .scale_o(sel_scale), .dur_o(sel_dur), .div32_o(div32)
  );

  jaloop_hold #(.DUR_W(DUR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(ptr_adj), .dur_i(sel_dur),
    .div32_i(div32), .first_o(first_order)
  );

  jaloop_filter #(
    .FILL_W(FILL_W), .GAIN_W(GAIN_W), .SCALE_W(SCALE_W), .FCW_W(FCW_W),
    .NOM_FCW(NOM_FCW)
  ) u_filt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .fill_i(fill_level),
    .first_i(first_order), .gain_i(sel_gain), .scale_i(sel_scale),
    .fcw_o(freq_word)
  );

  assign loop_order = first_order ? ORDER_FIRST : ORDER_SECOND;

  assert_order_follows_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adj && sel_dur != '0) |=> loop_order);
endmodule

// File: tb/jaloop_ctrl_test.sv
module jaloop_ctrl_test;
  localparam longint NOM  = 64'h800000;
  localparam longint FMAX = 64'hFFFFFF;
  localparam longint AMAX = (64'd1 << 27) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  fill_level = 8'd128;
  logic        ptr_adj = 1'b0;
  logic        mode_ds1 = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [26:0] cfg_wdata = '0;
  logic [23:0] freq_word;
  logic        loop_order;

  int total = 0;
  int bad = 0;
  longint m_acc;
  longint m_gain [2];
  longint m_scale [2];
  bit m_first;

  jaloop_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fill_level(fill_level),
    .ptr_adj(ptr_adj), .mode_ds1(mode_ds1), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .freq_word(freq_word),
    .loop_order(loop_order)
  );

  always #4ns clk = ~clk;

  task automatic check(input string req, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; ptr_adj = 1'b0; cfg_we = 1'b0; mode_ds1 = 1'b0;
    fill_level = 8'd128;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_acc = 0; m_first = 0;
    for (int i = 0; i < 2; i++) begin m_gain[i] = 0; m_scale[i] = 0; end
  endtask

  // R9 address map
  task automatic wr(input logic [2:0] a, input longint d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 27'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 3'd0) m_gain[0] = d;
    if (a == 3'd1) m_scale[0] = d;
    if (a == 3'd4) m_gain[1] = d;
    if (a == 3'd5) m_scale[1] = d;
  endtask

  function automatic longint expect_fw(input longint fill);
    longint e, integ, tot, mag;
    int s;
    s = mode_ds1 ? 1 : 0;
    e = fill - 128;
    integ = 0;
    if (!m_first) begin
      m_acc = m_acc + e;
      if (m_acc > AMAX) m_acc = AMAX;
      if (m_acc < -AMAX) m_acc = -AMAX;
      mag = (m_acc < 0) ? -m_acc : m_acc;
      if (mag > m_gain[s]) integ = m_acc;
    end
    tot = NOM + e * m_scale[s] + integ;
    if (tot < 0) tot = 0;
    if (tot > FMAX) tot = FMAX;
    return tot;
  endfunction

  task automatic do_tick(input int fill, input string req);
    longint exp;
    tick = 1'b1; fill_level = 8'(fill);
    exp = expect_fw(fill);
    @(negedge clk);
    tick = 1'b0;
    check(req, freq_word, exp);
  endtask

  task automatic pulse_ptr();
    ptr_adj = 1'b1;
    @(negedge clk);
    ptr_adj = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R1 reset freq_word", freq_word, NOM);
    check("R1 reset loop_order", loop_order, 0);
    pulse_ptr();
    check("R10 zero duration", loop_order, 0);
    repeat (5) @(negedge clk);
    check("R10 zero duration later", loop_order, 0);
  endtask

  task automatic t_prop();
    do_reset();
    wr(3'd0, AMAX); wr(3'd1, 100);
    wr(3'd4, AMAX); wr(3'd5, 3);
    do_tick(138, "R2 E1 positive error");
    check("R2 E1 value", freq_word, NOM + 1000);
    do_tick(100, "R2 E1 negative error");
    mode_ds1 = 1'b1;
    do_tick(150, "R2 DS1 scale");
    check("R2 DS1 value", freq_word, NOM + 66);
    fill_level = 8'd10;
    repeat (3) @(negedge clk);
    check("R4 no tick no change", freq_word, NOM + 66);
  endtask

  task automatic t_integ();
    do_reset();
    wr(3'd0, 25); wr(3'd1, 0);
    for (int i = 0; i < 5; i++) do_tick(133, "R3 below threshold");
    check("R3 equal threshold excluded", freq_word, NOM);
    do_tick(133, "R3 above threshold");
    check("R3 above threshold value", freq_word, NOM + 30);
  endtask

  task automatic t_sat();
    do_reset();
    wr(3'd1, 65535);
    do_tick(0, "R4 low side");
    do_tick(0, "R4 low side");
    check("R4 clamp to zero", freq_word, 0);
    for (int i = 0; i < 600; i++) do_tick(255, "R4 climb");
    check("R4 clamp to top", freq_word, FMAX);
  endtask

  task automatic window(input longint len, input string req);
    pulse_ptr();
    check(req, loop_order, 1);
    repeat (int'(len) - 1) @(negedge clk);
    check(req, loop_order, 1);
    @(negedge clk);
    check(req, loop_order, 0);
  endtask

  task automatic t_hold();
    do_reset();
    wr(3'd2, 3); wr(3'd6, 1);
    window(48, "R6 E1 div16 window R5");
    wr(3'd3, 1);
    window(96, "R6 E1 div32 window");
    wr(3'd3, 0);
    mode_ds1 = 1'b1;
    window(16, "R5 DS1 duration");
    mode_ds1 = 1'b0;
  endtask

  task automatic t_reload();
    do_reset();
    wr(3'd2, 4);
    pulse_ptr();
    repeat (40) @(negedge clk);
    pulse_ptr();
    repeat (63) @(negedge clk);
    check("R7 still first after reload", loop_order, 1);
    @(negedge clk);
    check("R7 ends full duration after reload", loop_order, 0);
  endtask

  task automatic t_freeze();
    do_reset();
    wr(3'd2, 1);
    do_tick(133, "R8 pre freeze");
    do_tick(133, "R8 pre freeze");
    check("R8 integral before", freq_word, NOM + 10);
    pulse_ptr();
    m_first = 1;
    do_tick(135, "R8 integral removed");
    check("R8 removed value", freq_word, NOM);
    repeat (20) @(negedge clk);
    check("R8 back to second order", loop_order, 0);
    m_first = 0;
    do_tick(128, "R8 held accumulator");
    check("R8 held value", freq_word, NOM + 10);
  endtask

  initial begin
    #1200us;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_prop();
    t_integ();
    t_sat();
    t_hold();
    t_reload();
    t_freeze();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule